// File: doc/BRIEF.md
# Six-Channel Power Sequencing Controller

This block drives six power-enable outputs. It switches them on in a programmed order when a power request rises, and switches them off again when the request falls. Each channel has a 3-bit sequence position. Channels that share a position switch in the same cycle. A common programmable delay separates the steps, and positions that hold no eligible channel are skipped. A mask bit per channel decides whether the channel takes part at all. A configuration bit selects whether power-off walks the positions in the same ascending order as power-on or in descending order.

Power-on starts only from idle, while the controller is armed and the request is high, and only when every unmasked channel reports its supply good. The supply flags are looked at only before the start; once sequencing runs they are ignored. The active-low force-off input clears every enable asynchronously and returns the controller to idle. The controller then stays disarmed until the request has been seen low while force-off is released. Reset leaves the controller disarmed in the same way.

All configuration inputs are plain levels and must stay unchanged while the controller is not idle. No data stream passes through the block, so it has no valid/ready handshake. Every pin is a control or status level.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset, pwr_en is 0, busy is 0 and seq_done is 0.
- R2: Power-on starts at the first clock edge that finds all of the following: the controller is idle and armed, power_req is high, and supply_ok is 1 on every channel whose chan_mask bit is 1. The first group of enables rises at the next clock edge after that.
- R3: Power-on enables the unmasked channels in ascending order of position (chan_pos bits [3c+2:3c] hold the position of channel c). All channels of one position rise in the same cycle. Positions holding no unmasked channel are skipped. Consecutive steps are step_dly+1 cycles apart.
- R4: A channel whose chan_mask bit is 0 never asserts pwr_en, and its supply_ok value does not block the start.
- R5: seq_done rises at the clock edge that enables the last group, and it clears at the edge where power-off begins. busy is 1 while power-on or power-off is stepping, and 0 in idle and in the done state.
- R6: When the controller sees power_req low while powering on or done, it enters power-off at that edge. The first group falls at the next edge, and later groups follow step_dly+1 cycles apart. The order is ascending position when off_reverse is 0 and descending when it is 1. After the last group falls the controller is idle.
- R7: If power_req falls before power-on completes, the controller stops enabling channels. Power-off then switches off only the channels already on, in the selected order.
- R8: force_off_n low clears pwr_en, busy and seq_done at once, without waiting for a clock edge, and leaves the controller idle.
- R9: After a reset or a force-off, no power-on starts until power_req has been sampled low while force_off_n is high. A request held high across the force-off does not restart the controller.
- R10: Changes of supply_ok after power-on has started have no effect on the stepping.
- R11: With chan_mask all zero, a valid start sets seq_done at the starting edge, with busy 0 and pwr_en 0. Dropping power_req then clears seq_done at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| force_off_n | input | 1 | Asynchronous active-low force shutdown |
| power_req | input | 1 | Power on (high) / off (low) request |
| off_reverse | input | 1 | 1: power-off in descending position order |
| step_dly | input | DLYW | Delay between steps, in cycles minus one |
| chan_mask | input | NCH | Per-channel participation mask |
| chan_pos | input | NCH*POSW | Per-channel sequence position |
| supply_ok | input | NCH | Per-channel supply good flags |
| pwr_en | output | NCH | Power-enable outputs |
| busy | output | 1 | Sequencing in progress |
| seq_done | output | 1 | Power-on sequence complete |

## Verification
A request change driven in the cycle numbered k reaches the controller state at edge k+1. The first enable change therefore appears at edge k+2, and step j of the sequence appears at edge k+2+j*(step_dly+1). The bench works out each of these edge numbers from the configured delay and the expected group order. It places each expected enable pattern, together with the busy and seq_done levels due at that step, in a queue keyed by cycle. A monitor compares the outputs in the middle of exactly that cycle. Force-off is checked one time unit after it is driven, with no clock edge in between. The no-start and ignored-input cases are checked by watching pwr_en and busy for several cycles.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ON   = 2'd1,
    ST_DONE = 2'd2,
    ST_OFF  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/seq_group_pick.sv
module seq_group_pick #(
  parameter int NCH  = 6,
  parameter int POSW = 3
) (
  input  logic [NCH-1:0]      cand,
  input  logic [NCH*POSW-1:0] pos_flat,
  input  logic                pick_high,
  output logic [NCH-1:0]      grp,
  output logic                any,
  output logic                rest_empty
);
  localparam int NPOS = 1 << POSW;

  logic [NPOS-1:0] occ;
  logic [POSW-1:0] sel;

  always_comb begin
    occ = '0;
    for (int p = 0; p < NPOS; p++) begin
      for (int c = 0; c < NCH; c++) begin
        if (cand[c] && (pos_flat[c*POSW +: POSW] == POSW'(p))) occ[p] = 1'b1;
      end
    end
  end

  // lowest occupied position, or highest when pick_high
  always_comb begin
    sel = '0;
    if (pick_high) begin
      for (int p = 0; p < NPOS; p++) begin
        if (occ[p]) sel = POSW'(p);
      end
    end else begin
      for (int p = NPOS - 1; p >= 0; p--) begin
        if (occ[p]) sel = POSW'(p);
      end
    end
  end

  assign any = |occ;

  genvar gc;
  generate
    for (gc = 0; gc < NCH; gc++) begin : g_grp
      assign grp[gc] = cand[gc] && any && (pos_flat[gc*POSW +: POSW] == sel);
    end
  endgenerate

  assign rest_empty = ((cand & ~grp) == '0);
endmodule

// File: rtl/seq_step_timer.sv
module seq_step_timer #(
  parameter int DLYW = 16
) (
  input  logic            clk,
  input  logic            kill_n,
  input  logic            clr,
  input  logic            load,
  input  logic [DLYW-1:0] load_val,
  output logic            zero
);
  logic [DLYW-1:0] cnt;

  always_ff @(posedge clk or negedge kill_n) begin
    if (!kill_n)         cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  AST_TMR_COUNTDOWN: assert property (@(posedge clk) disable iff (!kill_n)
    (!$past(clr) && !$past(load) && $past(cnt) != '0) |-> (cnt == $past(cnt) - 1'b1)); // R3

  AST_TMR_CLEAR: assert property (@(posedge clk) disable iff (!kill_n)
    $past(clr) |-> zero); // R6
endmodule

// File: rtl/seq_arm.sv
module seq_arm #(
  parameter int NCH = 6
) (
  input  logic           clk,
  input  logic           kill_n,
  input  logic           power_req,
  input  logic [NCH-1:0] supply_ok,
  input  logic [NCH-1:0] chan_mask,
  output logic           armed,
  output logic           pre_ok
);
  always_ff @(posedge clk or negedge kill_n) begin
    if (!kill_n)         armed <= 1'b0;
    else if (!power_req) armed <= 1'b1;
  end

  assign pre_ok = &(supply_ok | ~chan_mask);

  AST_ARM_NEEDS_LOW: assert property (@(posedge clk) disable iff (!kill_n)
    $rose(armed) |-> !$past(power_req)); // R9
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int NCH  = 6,
  parameter int POSW = 3,
  parameter int DLYW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                force_off_n,
  input  logic                power_req,
  input  logic                off_reverse,
  input  logic [DLYW-1:0]     step_dly,
  input  logic [NCH-1:0]      chan_mask,
  input  logic [NCH*POSW-1:0] chan_pos,
  input  logic [NCH-1:0]      supply_ok,
  output logic [NCH-1:0]      pwr_en,
  output logic                busy,
  output logic                seq_done
);
  logic kill_n;
  assign kill_n = rst_n & force_off_n;

  seq_state_t     st;
  logic [NCH-1:0] en_q;
  logic           done_q;

  logic           armed, pre_ok;
  logic [NCH-1:0] on_cand, on_grp, off_grp;
  logic           on_any, on_last, off_any, off_last;
  logic           tmr_zero, tmr_clr, tmr_load, start;

  assign on_cand = chan_mask & ~en_q;

  seq_arm #(.NCH(NCH)) u_arm (
    .clk(clk), .kill_n(kill_n), .power_req(power_req),
    .supply_ok(supply_ok), .chan_mask(chan_mask),
    .armed(armed), .pre_ok(pre_ok)
  );

  seq_group_pick #(.NCH(NCH), .POSW(POSW)) u_on_pick (
    .cand(on_cand), .pos_flat(chan_pos), .pick_high(1'b0),
    .grp(on_grp), .any(on_any), .rest_empty(on_last)
  );

  seq_group_pick #(.NCH(NCH), .POSW(POSW)) u_off_pick (
    .cand(en_q), .pos_flat(chan_pos), .pick_high(off_reverse),
    .grp(off_grp), .any(off_any), .rest_empty(off_last)
  );

  seq_step_timer #(.DLYW(DLYW)) u_tmr (
    .clk(clk), .kill_n(kill_n), .clr(tmr_clr), .load(tmr_load),
    .load_val(step_dly), .zero(tmr_zero)
  );

  assign start = (st == ST_IDLE) && armed && power_req && pre_ok;

  always_comb begin
    tmr_clr  = 1'b0;
    tmr_load = 1'b0;
    unique case (st)
      ST_IDLE: tmr_clr = start;
      ST_ON: begin
        if (!power_req)                              tmr_clr  = 1'b1;
        else if (tmr_zero && on_any && !on_last)     tmr_load = 1'b1;
      end
      ST_DONE: tmr_clr = !power_req;
      ST_OFF:  tmr_load = tmr_zero && off_any && !off_last;
      default: tmr_clr = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge kill_n) begin
    if (!kill_n) begin
      st     <= ST_IDLE;
      en_q   <= '0;
      done_q <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            if (on_cand != '0) st <= ST_ON;
            else begin
              st     <= ST_DONE;
              done_q <= 1'b1;
            end
          end
        end
        ST_ON: begin
          if (!power_req) st <= ST_OFF;
          else if (tmr_zero) begin
            if (!on_any) begin
              st     <= ST_DONE;
              done_q <= 1'b1;
            end else begin
              en_q <= en_q | on_grp;
              if (on_last) begin
                st     <= ST_DONE;
                done_q <= 1'b1;
              end
            end
          end
        end
        ST_DONE: begin
          if (!power_req) begin
            st     <= ST_OFF;
            done_q <= 1'b0;
          end
        end
        ST_OFF: begin
          if (tmr_zero) begin
            if (!off_any) st <= ST_IDLE;
            else begin
              en_q <= en_q & ~off_grp;
              if (off_last) st <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign pwr_en   = en_q;
  assign busy     = (st == ST_ON) || (st == ST_OFF);
  assign seq_done = done_q;

  AST_MASK_HONOURED: assert property (@(posedge clk) disable iff (!kill_n)
    ((en_q & ~$past(en_q) & ~$past(chan_mask)) == '0)); // R4

  AST_START_PRECOND: assert property (@(posedge clk) disable iff (!kill_n)
    (st == ST_ON && $past(st) == ST_IDLE) |-> $past(power_req && pre_ok && armed)); // R2

  AST_ON_NO_DROP: assert property (@(posedge clk) disable iff (!kill_n)
    ($past(st) == ST_ON && st == ST_ON) |-> ((en_q & $past(en_q)) == $past(en_q))); // R3

  AST_OFF_NO_RISE: assert property (@(posedge clk) disable iff (!kill_n)
    ($past(st) == ST_OFF) |-> ((en_q & ~$past(en_q)) == '0)); // R6

  AST_DONE_FULL: assert property (@(posedge clk) disable iff (!kill_n)
    seq_done |-> (pwr_en == chan_mask && !busy)); // R5

  AST_OFF_ON_DROP: assert property (@(posedge clk) disable iff (!kill_n)
    ($past(st) == ST_ON && !$past(power_req)) |-> (st == ST_OFF && pwr_en == $past(pwr_en))); // R7

  AST_FORCE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !force_off_n |-> (pwr_en == '0 && !busy && !seq_done)); // R8
endmodule

// File: tb/pwr_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_tb_top;
  localparam int NCH = 6, POSW = 3, DLYW = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, force_off_n, power_req, off_reverse;
  logic [DLYW-1:0] step_dly;
  logic [NCH-1:0] chan_mask, supply_ok, pwr_en;
  logic [NCH*POSW-1:0] chan_pos;
  logic busy, seq_done;

  pwr_seq_ctrl #(.NCH(NCH), .POSW(POSW), .DLYW(DLYW)) dut_i (
    .clk(clk), .rst_n(rst_n), .force_off_n(force_off_n), .power_req(power_req),
    .off_reverse(off_reverse), .step_dly(step_dly), .chan_mask(chan_mask),
    .chan_pos(chan_pos), .supply_ok(supply_ok), .pwr_en(pwr_en),
    .busy(busy), .seq_done(seq_done)
  );

  typedef struct {
    int         cyc;
    logic [5:0] en;
    logic       bsy;
    logic       dn;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int cyc = 0;
  int n_chk = 0, n_fail = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  // monitor: compare outputs at the mid-cycle point of each due cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      if (sb[0].cyc < cyc) begin
        n_chk++; n_fail++;
        $display("FAIL %s: item for cycle %0d missed, got %0h expected %0h",
                 sb[0].tag, sb[0].cyc, pwr_en, sb[0].en);
      end else begin
        check({sb[0].tag, " pwr_en"}, int'(pwr_en), int'(sb[0].en));
        check({sb[0].tag, " busy"}, int'(busy), int'(sb[0].bsy));
        check({sb[0].tag, " seq_done"}, int'(seq_done), int'(sb[0].dn));
      end
      void'(sb.pop_front());
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // push expected steps: step i due at first + i*gap
  task automatic push_seq(int first, int gap, logic [5:0] vals[$], bit is_on,
                          bit complete, string tag);
    for (int i = 0; i < vals.size(); i++) begin
      exp_t e;
      e.cyc = first + i * gap;
      e.en  = vals[i];
      e.bsy = !(complete && i == vals.size() - 1);
      e.dn  = is_on && complete && i == vals.size() - 1;
      e.tag = tag;
      sb.push_back(e);
    end
  endtask

  task automatic drain();
    wait (sb.size() == 0);
    tick();
  endtask

  initial begin
    int k;
    int gap;
    rst_n = 1'b0; force_off_n = 1'b1; power_req = 1'b0; off_reverse = 1'b0;
    step_dly = 16'd2; chan_mask = 6'h3F; supply_ok = 6'h3F;
    chan_pos = {3'd2, 3'd7, 3'd0, 3'd5, 3'd0, 3'd2};
    ticks(3);
    check("R1 pwr_en", int'(pwr_en), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 seq_done", int'(seq_done), 0);
    rst_n = 1'b1;
    ticks(3);
    check("R1 pwr_en after release", int'(pwr_en), 0);
    gap = 3;

    // ascending on, same-order off
    power_req = 1'b1; k = cyc;
    push_seq(k + 2, gap, '{6'h0A, 6'h2B, 6'h2F, 6'h3F}, 1, 1, "R3 R5 on order");
    drain();
    ticks(2);
    check("R5 done held", int'(seq_done), 1);
    power_req = 1'b0; k = cyc;
    tick();
    check("R5 done clears at off start", int'(seq_done), 0);
    check("R5 busy in off", int'(busy), 1);
    push_seq(k + 2, gap, '{6'h35, 6'h14, 6'h10, 6'h00}, 0, 1, "R6 off same order");
    drain();

    // masked channel, its supply flag low, reverse off
    chan_mask = 6'h3B; supply_ok = 6'h3B; off_reverse = 1'b1;
    tick();
    power_req = 1'b1; k = cyc;
    push_seq(k + 2, gap, '{6'h0A, 6'h2B, 6'h3B}, 1, 1, "R4 masked on");
    drain();
    power_req = 1'b0; k = cyc;
    push_seq(k + 2, gap, '{6'h2B, 6'h0A, 6'h00}, 0, 1, "R6 reverse off");
    drain();

    // precondition blocks start, then abort mid power-on
    chan_mask = 6'h3F; supply_ok = 6'h3E; off_reverse = 1'b0;
    tick();
    power_req = 1'b1;
    ticks(6);
    check("R2 blocked pwr_en", int'(pwr_en), 0);
    check("R2 blocked busy", int'(busy), 0);
    supply_ok = 6'h3F; k = cyc;
    push_seq(k + 2, gap, '{6'h0A}, 1, 0, "R2 start after supply good");
    drain();
    supply_ok = 6'h1F;  // R10: ignored while stepping
    k = cyc - 1;
    push_seq(k + gap, gap, '{6'h2B}, 1, 0, "R10 supply drop ignored");
    drain();
    power_req = 1'b0; k = cyc - 1;
    push_seq(k + 2 + 1, gap, '{6'h21, 6'h00}, 0, 1, "R7 abort off");
    drain();
    supply_ok = 6'h3F;
    ticks(4);
    check("R7 idle pwr_en", int'(pwr_en), 0);

    // force shutdown mid power-on, re-arm rule
    power_req = 1'b1; k = cyc;
    push_seq(k + 2, gap, '{6'h0A}, 1, 0, "R8 pre-force step");
    drain();
    force_off_n = 1'b0;
    #1;
    check("R8 force pwr_en", int'(pwr_en), 0);
    check("R8 force busy", int'(busy), 0);
    check("R8 force seq_done", int'(seq_done), 0);
    tick();
    force_off_n = 1'b1;
    ticks(10);
    check("R9 no restart pwr_en", int'(pwr_en), 0);
    check("R9 no restart busy", int'(busy), 0);
    power_req = 1'b0;
    tick();
    power_req = 1'b1; k = cyc;
    off_reverse = 1'b1;
    push_seq(k + 2, gap, '{6'h0A, 6'h2B, 6'h2F, 6'h3F}, 1, 1, "R9 rearmed on");
    drain();
    power_req = 1'b0; k = cyc;
    push_seq(k + 2, gap, '{6'h2F, 6'h2B, 6'h0A, 6'h00}, 0, 1, "R6 reverse full off");
    drain();

    // no channels enabled
    chan_mask = 6'h00; supply_ok = 6'h00;
    tick();
    power_req = 1'b1;
    tick();
    check("R11 done", int'(seq_done), 1);
    check("R11 busy", int'(busy), 0);
    check("R11 pwr_en", int'(pwr_en), 0);
    power_req = 1'b0;
    tick();
    check("R11 done clears", int'(seq_done), 0);
    ticks(2);
    check("R11 idle busy", int'(busy), 0);

    // zero delay: one cycle between steps
    chan_mask = 6'h3F; supply_ok = 6'h3F; step_dly = 16'd0; off_reverse = 1'b0;
    tick();
    power_req = 1'b1; k = cyc;
    push_seq(k + 2, 1, '{6'h0A, 6'h2B, 6'h2F, 6'h3F}, 1, 1, "R3 zero delay on");
    drain();
    power_req = 1'b0; k = cyc;
    push_seq(k + 2, 1, '{6'h35, 6'h14, 6'h10, 6'h00}, 0, 1, "R6 zero delay off");
    drain();
    ticks(3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule